// File: doc/BRIEF.md
# Register-Chain Synchronous FIFO

This block is a small first-in-first-out buffer built without a memory array or address pointers. Its storage is a line of data registers. On a read, every register takes the word held by its neighbour one step further from the output, so words advance toward the head stage. A second line of one-bit registers, one per data stage, records which stages hold valid words. Because valid stages always form a contiguous run that starts at the head, that occupancy vector also behaves as a shift register. The full and empty flags come straight from its end bits, and the write target is chosen from it too.

A producer pulses the write strobe with a word, and a consumer pulses the read strobe. The head word is always visible on the data output. The output, full and empty are all register outputs, so no input reaches an output in the same cycle. Depth and width are parameters and default to 4 stages of 8 bits. Reset is synchronous and active high.

Top module: `shift_fifo`

## Requirements
- R1: While reset is high at a clock edge, all occupancy is cleared and all data stages are zeroed. After that edge, empty is 1, full is 0 and the data output is 0.
- R2: Words are read out in exactly the order in which they were accepted, and no word is lost or duplicated.
- R3: A write strobe while full is high and read is low is ignored. The FIFO stays full and the stored words and their order are unchanged.
- R4: A read strobe while empty is high and write is low is ignored. The FIFO stays empty, and later writes are read out unaffected.
- R5: When read and write are both high and the FIFO is neither empty nor full, one word is removed and one is accepted. The full and empty flags keep their values, and the order of the remaining words is preserved.
- R6: The data output shows the oldest stored word whenever empty is 0. It changes only on the clock edge after an accepted read, or on the edge after a write into an empty FIFO.
- R7: Full is 1 exactly when DEPTH words are stored, and empty is 1 exactly when no word is stored. The two are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr | input | 1 | Write strobe |
| din | input | WIDTH | Write data |
| rd | input | 1 | Read strobe |
| dout | output | WIDTH | Oldest stored word (registered) |
| full | output | 1 | All stages occupied (registered) |
| empty | output | 1 | No stage occupied (registered) |

## Verification
The bench targets the transitions where a shifting store tends to break:
- **Write while full:** a design that let this write through would overwrite or push out the last stage, so a word would go missing on the drain that follows.
- **Read while empty:** a design that did not ignore it would clear a flag or shift in a stale word, and empty would drop with garbage at the head.
- **Simultaneous read and write:** if the write were placed before the shift, the new word would land one stage too far up, leaving a hole or a duplicate.
- **Write into an empty FIFO:** a wrong head-load path would present the word late, or not at all.

Random traffic with forced bursts up to full and down to empty covers the mixed cases, checked every cycle against a queue.

// File: rtl/shift_fifo.sv
module shift_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [WIDTH-1:0] din,
  input  logic             rd,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] stage_q [DEPTH];
  logic [DEPTH-1:0] occ_q;
  logic [DEPTH-1:0] occ_shift;
  logic [DEPTH-1:0] slot;
  logic [DEPTH:0]   occ_below;
  logic             pop, push;

  assign pop  = rd & occ_q[0];
  assign push = wr & ~occ_q[DEPTH-1];

  assign occ_shift = pop ? {1'b0, occ_q[DEPTH-1:1]} : occ_q;
  assign occ_below = {occ_shift, 1'b1};

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_stage
      assign slot[i] = push & ~occ_shift[i] & occ_below[i];

      if (i < DEPTH-1) begin : g_mid
        always_ff @(posedge clk) begin
          if (rst)          stage_q[i] <= '0;
          else if (slot[i]) stage_q[i] <= din;
          else if (pop)     stage_q[i] <= stage_q[i+1];
        end
      end else begin : g_top
        always_ff @(posedge clk) begin
          if (rst)          stage_q[i] <= '0;
          else if (slot[i]) stage_q[i] <= din;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) occ_q <= '0;
    else     occ_q <= occ_shift | slot;
  end

  assign dout  = stage_q[0];
  assign full  = occ_q[DEPTH-1];
  assign empty = ~occ_q[0];

endmodule

// File: rtl/shift_fifo_chk.sv
module shift_fifo_chk #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr,
  input logic [WIDTH-1:0] din,
  input logic             rd,
  input logic [WIDTH-1:0] dout,
  input logic             full,
  input logic             empty
);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (empty && !full && dout == '0));

  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wr && !rd) |=> (full && $stable(dout)));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && rd && !wr) |=> empty);

  p_first_word_r6: assert property (@(posedge clk) disable iff (rst)
    (empty && wr && !rd) |=> (!empty && dout == $past(din)));

  p_hold_without_read_r6: assert property (@(posedge clk) disable iff (rst)
    (!empty && !rd) |=> $stable(dout));

  p_swap_keeps_flags_r5: assert property (@(posedge clk) disable iff (rst)
    (!empty && !full && rd && wr) |=> ($stable(full) && $stable(empty)));

endmodule

bind shift_fifo shift_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .wr(wr), .din(din), .rd(rd),
  .dout(dout), .full(full), .empty(empty)
);

// File: tb/shift_fifo_tb.sv
`timescale 1ns/1ps
module shift_fifo_tb;
  localparam int DEPTH = 4;
  localparam int WIDTH = 8;

  logic             clk = 0;
  logic             rst = 1;
  logic             wr = 0, rd = 0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic             full, empty;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [WIDTH-1:0] model_q [$];

  always #2 clk = ~clk;

  shift_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst(rst), .wr(wr), .din(din), .rd(rd),
    .dout(dout), .full(full), .empty(empty)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "empty", int'(empty), int'(model_q.size() == 0));
    check(tag, "full", int'(full), int'(model_q.size() == DEPTH));
    if (model_q.size() > 0) check(tag, "dout", int'(dout), int'(model_q[0]));
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic w, input logic r, input logic [WIDTH-1:0] d, input string tag);
    bit pop_ok, push_ok;
    wr = w; rd = r; din = d;
    @(posedge clk);
    pop_ok  = r && model_q.size() > 0;
    push_ok = w && model_q.size() < DEPTH;
    if (pop_ok)  void'(model_q.pop_front());
    if (push_ok) model_q.push_back(d);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1", "empty", int'(empty), 1);
    check("R1", "full", int'(full), 0);
    check("R1", "dout", int'(dout), 0);

    // R6: write into empty shows word on next edge
    step(1, 0, 8'hA5, "R6");
    // R7: fill to full
    for (int k = 1; k < DEPTH; k++) step(1, 0, 8'(8'h10 + k), "R7");
    // R3: writes while full are ignored
    step(1, 0, 8'hEE, "R3");
    step(1, 0, 8'hDD, "R3");
    // R2: drain, order kept
    for (int k = 0; k < DEPTH; k++) step(0, 1, 8'h00, "R2");
    // R4: reads while empty are ignored
    step(0, 1, 8'h00, "R4");
    step(0, 1, 8'h00, "R4");
    step(1, 0, 8'h3C, "R4");
    step(0, 1, 8'h00, "R4");

    // R5: simultaneous read/write at partial fill
    step(1, 0, 8'h01, "R5");
    step(1, 0, 8'h02, "R5");
    for (int k = 0; k < 6; k++) step(1, 1, 8'(8'h40 + k), "R5");
    step(0, 1, 8'h00, "R5");
    step(0, 1, 8'h00, "R5");

    // R2/R7: random traffic with bursts
    for (int k = 0; k < 3000; k++) begin
      int mode = k / 200 % 3;
      logic w, r;
      if (mode == 0)      begin w = ($urandom % 4) != 0; r = ($urandom % 4) == 0; end
      else if (mode == 1) begin w = ($urandom % 4) == 0; r = ($urandom % 4) != 0; end
      else                begin w = $urandom % 2;         r = $urandom % 2;         end
      step(w, r, 8'($urandom), "R2");
    end

    // R1: reset mid-traffic clears contents
    step(1, 0, 8'h77, "R2");
    rst = 1;
    @(posedge clk);
    model_q.delete();
    @(negedge clk);
    rst = 0;
    check("R1", "empty", int'(empty), 1);
    check("R1", "full", int'(full), 0);
    check("R1", "dout", int'(dout), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule